// File: doc/BRIEF.md
# SPI Register Access Sniffer

This block watches a four-wire SPI link between a host and a radio transceiver without taking part in it. It takes byte pairs that have already been deserialised: one host-to-device byte and one device-to-host byte per strobe. It also takes a pulse marking each rising edge of chip-select. The block groups the bytes into register accesses and reports each finished access on a single-cycle strobe. The report gives the access form (short or long), the direction, the register address and the data byte that moved.

The form of an access is decided by the top bit of its first host byte, so an access is either two or three bytes long. The address and write-flag fields sit at different bit positions in the two forms. A chip-select rise ends any partial access. If the rise comes after exactly one byte, the block flags it as misplaced.

Top module: `spi_reg_sniffer`

## Requirements
- R1: A synchronous reset clears the byte count and drives `access_valid`, `cs_warn`, `is_long`, `is_write`, `addr` and `data` to zero. A chip-select rise in the first cycle after reset gives no warning.
- R2: When bit 7 of the first host byte is 0, the access is short. It completes on its second byte. `access_valid` is high, with `is_long` = 0, in the cycle after the clock edge that samples the second byte.
- R3: For a short access, `addr` is first-byte bits [6:1] with bits [9:6] of `addr` zero, and `is_write` is first-byte bit 0.
- R4: When bit 7 of the first host byte is 1, the access is long. No report follows its second byte. It completes on its third byte with `is_long` = 1, reported in the cycle after that byte is sampled.
- R5: For a long access, take word = first byte × 256 + second byte. `addr` is word bits [14:5] and `is_write` is word bit 4.
- R6: On a write, `data` is the host byte of the last byte of the access. On a read, it is the device byte of that last byte.
- R7: After an access completes, the next byte is taken as the first byte of a new access, so back-to-back accesses under one chip-select decode independently.
- R8: A chip-select rise while exactly one byte is collected raises `cs_warn` for one cycle, in the cycle after the rise. The partial byte is discarded.
- R9: A chip-select rise with no byte collected, or with two bytes of a long access collected, gives no warning. It still discards any partial access.
- R10: When `byte_valid` and `cs_rise` are high in the same cycle, the byte is dropped. The warning rule is applied to the count held before that cycle.
- R11: `access_valid` is high for exactly one cycle per completed access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_valid | input | 1 | One deserialised byte pair is present this cycle |
| mosi_byte | input | 8 | Host-to-device byte |
| miso_byte | input | 8 | Device-to-host byte |
| cs_rise | input | 1 | Pulse on a rising chip-select edge |
| access_valid | output | 1 | One-cycle strobe for a completed access |
| is_long | output | 1 | 1 for a three-byte access |
| is_write | output | 1 | 1 for a write access |
| addr | output | 10 | Register address |
| data | output | 8 | Data byte of the access |
| cs_warn | output | 1 | One-cycle misplaced chip-select flag |

## Verification
The hardest case to reach is a chip-select rise against a long access with exactly two bytes collected. It must discard those bytes silently. The bench sends the two leading bytes of a long access, raises chip-select, and then sends a short access, which shows the discarded bytes left nothing behind. The bench also drives a byte in the same cycle as a chip-select rise. Exhaustive sweeps cover every short first byte and every long two-byte header, back to back, with no idle cycles between accesses.

// File: rtl/spi_reg_sniffer.sv
module spi_reg_sniffer (
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_valid,
  input  logic [7:0] mosi_byte,
  input  logic [7:0] miso_byte,
  input  logic       cs_rise,
  output logic       access_valid,
  output logic       is_long,
  output logic       is_write,
  output logic [9:0] addr,
  output logic [7:0] data,
  output logic       cs_warn
);

  logic [1:0] cnt;
  logic [7:0] hdr0, hdr1;

  wire       take       = byte_valid && !cs_rise;
  wire       done_short = take && (cnt == 2'd1) && !hdr0[7];
  wire       done_long  = take && (cnt == 2'd2);
  wire       done       = done_short || done_long;
  wire [9:0] nxt_addr   = done_long ? {hdr0[6:0], hdr1[7:5]} : {4'd0, hdr0[6:1]};
  wire       nxt_wr     = done_long ? hdr1[4] : hdr0[0];
  wire [7:0] nxt_data   = nxt_wr ? mosi_byte : miso_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt          <= 2'd0;
      hdr0         <= 8'd0;
      hdr1         <= 8'd0;
      access_valid <= 1'b0;
      cs_warn      <= 1'b0;
      is_long      <= 1'b0;
      is_write     <= 1'b0;
      addr         <= 10'd0;
      data         <= 8'd0;
    end else begin
      access_valid <= done;
      cs_warn      <= cs_rise && (cnt == 2'd1);
      if (cs_rise) begin
        cnt <= 2'd0;
      end else if (take) begin
        cnt <= done ? 2'd0 : cnt + 2'd1;
        if (cnt == 2'd0) hdr0 <= mosi_byte;
        if (cnt == 2'd1) hdr1 <= mosi_byte;
      end
      if (done) begin
        is_long  <= done_long;
        is_write <= nxt_wr;
        addr     <= nxt_addr;
        data     <= nxt_data;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt != 2'd3); // R7
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst) access_valid |=> !access_valid); // R11
  AST_SHORT_DONE: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && !cs_rise && cnt == 2'd1 && !hdr0[7]) |=> (access_valid && !is_long)); // R2
  AST_LONG_WAIT: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && !cs_rise && cnt == 2'd1 && hdr0[7]) |=> !access_valid); // R4
  AST_SHORT_ADDR: assert property (@(posedge clk) disable iff (rst)
    (access_valid && !is_long) |-> addr[9:6] == 4'd0); // R3
  AST_CS_CLEARS: assert property (@(posedge clk) disable iff (rst) cs_rise |=> cnt == 2'd0); // R8
  AST_QUIET_CS: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && cnt != 2'd1) |=> !cs_warn); // R9
  AST_CS_WINS: assert property (@(posedge clk) disable iff (rst) cs_rise |=> !access_valid); // R10

endmodule

// File: tb/spi_reg_sniffer_bench.sv
module spi_reg_sniffer_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst, bv, cr;
  logic [7:0] mo, mi;
  logic       access_valid, is_long, is_write, cs_warn;
  logic [9:0] addr;
  logic [7:0] data;

  spi_reg_sniffer u_spi_reg_sniffer (
    .clk(clk), .rst(rst), .byte_valid(bv), .mosi_byte(mo), .miso_byte(mi),
    .cs_rise(cr), .access_valid(access_valid), .is_long(is_long),
    .is_write(is_write), .addr(addr), .data(data), .cs_warn(cs_warn)
  );

  int total = 0;
  int bad = 0;
  int mcnt = 0;
  logic [7:0] f0, f1;

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] m, input logic [7:0] s,
                      input logic c, input string tag);
    logic ev, el, ew, ewarn;
    logic [9:0] ea;
    logic [7:0] ed;
    int word;
    ev = 0; el = 0; ew = 0; ea = 0; ed = 0;
    bv = v; mo = m; mi = s; cr = c;
    ewarn = c && (mcnt == 1);
    if (c) mcnt = 0;
    else if (v) begin
      if (mcnt == 0) begin
        f0 = m; mcnt = 1;
      end else if (mcnt == 1 && f0 < 128) begin
        ev = 1; ea = 10'((f0 / 2) % 64); ew = f0[0]; ed = ew ? m : s; mcnt = 0;
      end else if (mcnt == 1) begin
        f1 = m; mcnt = 2;
      end else begin
        word = int'(f0) * 256 + int'(f1);
        ev = 1; el = 1; ea = 10'((word / 32) % 1024); ew = ((word / 16) % 2) == 1;
        ed = ew ? m : s; mcnt = 0;
      end
    end
    @(negedge clk);
    bv = 0; cr = 0;
    chk(tag, "access_valid", 16'(access_valid), 16'(ev));
    chk(tag, "cs_warn", 16'(cs_warn), 16'(ewarn));
    if (ev) begin
      chk(el ? "R4" : "R2", "is_long", 16'(is_long), 16'(el));
      chk(el ? "R5" : "R3", "addr", 16'(addr), 16'(ea));
      chk(el ? "R5" : "R3", "is_write", 16'(is_write), 16'(ew));
      chk("R6", "data", 16'(data), 16'(ed));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; bv = 0; cr = 0; mo = 0; mi = 0;
    repeat (3) @(negedge clk);
    chk("R1", "access_valid", 16'(access_valid), 16'd0);
    chk("R1", "cs_warn", 16'(cs_warn), 16'd0);
    chk("R1", "is_long", 16'(is_long), 16'd0);
    chk("R1", "is_write", 16'(is_write), 16'd0);
    chk("R1", "addr", 16'(addr), 16'd0);
    chk("R1", "data", 16'(data), 16'd0);
    rst = 0;
    mcnt = 0;
    step(0, 8'h00, 8'h00, 1, "R1");

    for (int f = 0; f < 128; f++)
      for (int k = 0; k < 4; k++) begin
        step(1, 8'(f), 8'(~f), 0, "R2");
        step(1, 8'((f * 37 + k * 91) % 256), 8'((f * 11 + k * 53 + 7) % 256), 0, "R7");
      end
    step(0, 8'h00, 8'h00, 0, "R11");

    for (int w = 0; w < 32768; w++) begin
      step(1, 8'(128 + w / 256), 8'(w * 3), 0, "R4");
      step(1, 8'(w % 256), 8'(w / 128), 0, "R4");
      step(1, 8'((w * 7) % 256), 8'((w * 13 + 5) % 256), 0, "R5");
    end
    step(0, 8'h00, 8'h00, 0, "R11");

    step(1, 8'h10, 8'h00, 0, "R8");
    step(0, 8'h00, 8'h00, 1, "R8");
    step(1, 8'h05, 8'hAA, 0, "R8");
    step(1, 8'h3C, 8'h5A, 0, "R8");

    step(0, 8'h00, 8'h00, 1, "R9");
    step(1, 8'hC3, 8'h00, 0, "R9");
    step(1, 8'h9F, 8'h00, 0, "R9");
    step(0, 8'h00, 8'h00, 1, "R9");
    step(1, 8'h44, 8'h11, 0, "R9");
    step(1, 8'h77, 8'hE1, 0, "R9");

    step(1, 8'h81, 8'h00, 0, "R10");
    step(1, 8'h22, 8'h00, 1, "R10");
    step(1, 8'h2B, 8'h19, 0, "R10");
    step(0, 8'h00, 8'h00, 0, "R10");
    step(1, 8'h66, 8'h93, 0, "R10");
    step(1, 8'h1D, 8'h48, 1, "R10");
    step(1, 8'hFF, 8'h01, 0, "R7");
    step(0, 8'h00, 8'h00, 0, "R4");
    step(1, 8'hE0, 8'h02, 0, "R4");
    step(0, 8'h00, 8'h00, 0, "R4");
    step(1, 8'hC9, 8'h7E, 0, "R6");
    step(0, 8'h00, 8'h00, 0, "R11");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule